// File: doc/BRIEF.md
# DDR3 Power-Up Reset and Clock-Enable Sequencer

This block drives the memory reset line (active low) and the clock-enable line of a DDR3 device through the power-up part of initialization. It waits for a power-good input. It then holds reset low for a minimum time and keeps clock-enable low across the release of reset. After release it keeps clock-enable low for the required wait, lets the clock run for a minimum number of cycles, and then raises clock-enable. Clock-enable then stays high. A command-gate output forces idle commands while clock-enable is raised. A done flag hands control to the later initialization steps.

All intervals come from cycle counters. Each terminal count is a parameter computed as ceil(interval / clock period) and is never less than one cycle. The clock-run count is never less than five cycles. If the power-good input drops, or the master reset is asserted, the sequence starts again from the beginning.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: While rstN is low, or on the first clock edge after pwrStable is sampled low, the outputs are memResetN=0, memCke=0, cmdNop=1 and initDone=0. They keep these values for as long as pwrStable stays low.
- R2: Let E0 be the first rising edge at which pwrStable is sampled high while waiting. memResetN rises on edge E0+RST+SETUP and no earlier. RST is the reset-hold cycle count and SETUP is the CKE-setup cycle count.
- R3: memCke is low in the cycle in which memResetN rises, and it has been low for at least SETUP cycles before that.
- R4: memCke rises on edge E0+RST+SETUP+LOW+RUN. LOW is the post-reset low-wait count and RUN is the clock-run count.
- R5: cmdNop is 1 in the cycle in which memCke rises. cmdNop falls, and initDone rises, one edge after memCke rises.
- R6: Once memCke is high, memCke and initDone stay high while pwrStable stays high and rstN stays high.
- R7: A drop of pwrStable in any state, including the done state, restarts the full sequence. Every interval is counted again from the next E0.
- R8: Each count is ceil(interval_ps / period_ps), with a floor of 1. The clock-run count has a floor of 5. With a 10 ns period and intervals of 35 ns, 5 ns, 61 ns and 10 ns, the counts are 4, 1, 7 and 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Master reset, active low, asynchronous |
| pwrStable | input | 1 | High when the memory supplies are stable |
| memResetN | output | 1 | Memory reset, active low, registered |
| memCke | output | 1 | Memory clock enable, registered |
| cmdNop | output | 1 | High to force NOP/deselect on the command bus |
| initDone | output | 1 | High when the power-up step is complete |

## Verification
The assertions take pwrStable to be already synchronous to clk. They also take rstN to change only away from the rising edge. The bench changes both signals only on falling edges. It raises power only while the sequencer is waiting, so every sweep starts from a known E0. The power drops come mid-wait and after done, and each is followed by a fresh full sweep, so the restart is checked without overlapping sequences.

// File: rtl/ddr_pwrup_pkg.sv
`timescale 1ns / 1ps
package ddr_pwrup_pkg;

  typedef enum logic [2:0] {
    ST_WAIT_PWR,
    ST_RST_HOLD,
    ST_CKE_SETUP,
    ST_CKE_LOW,
    ST_CLK_RUN,
    ST_CKE_HIGH,
    ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_RST,
    PH_SETUP,
    PH_LOW,
    PH_RUN
  } phase_e;

  // Strobes from control to the interval timer
  typedef struct packed {
    logic   clr;    // restart the count at zero
    logic   run;    // count this cycle
    phase_e phase;  // which limit applies
  } tmr_strobe_t;

  // ceil(interval / period), never below floorCyc
  function automatic int cycles_for(longint intervalPs, longint periodPs, int floorCyc);
    longint c;
    c = (intervalPs + periodPs - 1) / periodPs;
    if (c < longint'(floorCyc)) c = longint'(floorCyc);
    return int'(c);
  endfunction

endpackage

// File: rtl/ddr_pwrup_timer.sv
`timescale 1ns / 1ps
module ddr_pwrup_timer
  import ddr_pwrup_pkg::*;
#(
  parameter int RST_CYC   = 4,
  parameter int SETUP_CYC = 1,
  parameter int LOW_CYC   = 7,
  parameter int RUN_CYC   = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  tmr_strobe_t strobe,
  output logic        tDone
);

  localparam int MAX_A   = (RST_CYC > SETUP_CYC) ? RST_CYC : SETUP_CYC;
  localparam int MAX_B   = (LOW_CYC > RUN_CYC) ? LOW_CYC : RUN_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int W       = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC + 1);

  localparam int NPH = 4;
  logic [W-1:0] lastVal [NPH];

  // One terminal value per phase
  for (genvar p = 0; p < NPH; p++) begin : g_lim
    localparam int CYC = (p == 0) ? RST_CYC : (p == 1) ? SETUP_CYC :
                         (p == 2) ? LOW_CYC : RUN_CYC;
    assign lastVal[p] = W'(CYC - 1);
  end

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (strobe.clr)   cnt <= '0;
    else if (strobe.run)   cnt <= cnt + 1'b1;
  end

  assign tDone = strobe.run && (cnt == lastVal[strobe.phase]);

  // R2: a running count never passes its phase limit
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rstN)
    strobe.run |-> (cnt <= lastVal[strobe.phase]));

endmodule

// File: rtl/ddr_pwrup_ctrl.sv
`timescale 1ns / 1ps
module ddr_pwrup_ctrl
  import ddr_pwrup_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pwrStable,
  input  logic        tDone,
  output tmr_strobe_t strobe,
  output logic        memResetN,
  output logic        memCke,
  output logic        cmdNop,
  output logic        initDone
);

  seq_state_e st, nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_WAIT_PWR:  if (pwrStable) nxt = ST_RST_HOLD;
      ST_RST_HOLD:  if (tDone) nxt = ST_CKE_SETUP;
      ST_CKE_SETUP: if (tDone) nxt = ST_CKE_LOW;
      ST_CKE_LOW:   if (tDone) nxt = ST_CLK_RUN;
      ST_CLK_RUN:   if (tDone) nxt = ST_CKE_HIGH;
      ST_CKE_HIGH:  nxt = ST_DONE;
      ST_DONE:      nxt = ST_DONE;
      default:      nxt = ST_WAIT_PWR;
    endcase
    if (!pwrStable) nxt = ST_WAIT_PWR;
  end

  always_comb begin
    strobe.clr   = (nxt != st);
    strobe.run   = 1'b0;
    strobe.phase = PH_RST;
    unique case (st)
      ST_RST_HOLD:  begin strobe.run = 1'b1; strobe.phase = PH_RST;   end
      ST_CKE_SETUP: begin strobe.run = 1'b1; strobe.phase = PH_SETUP; end
      ST_CKE_LOW:   begin strobe.run = 1'b1; strobe.phase = PH_LOW;   end
      ST_CLK_RUN:   begin strobe.run = 1'b1; strobe.phase = PH_RUN;   end
      default:      ;
    endcase
  end

  // Outputs decoded from the next state, so each changes on one edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st        <= ST_WAIT_PWR;
      memResetN <= 1'b0;
      memCke    <= 1'b0;
      cmdNop    <= 1'b1;
      initDone  <= 1'b0;
    end else begin
      st        <= nxt;
      memResetN <= nxt inside {ST_CKE_LOW, ST_CLK_RUN, ST_CKE_HIGH, ST_DONE};
      memCke    <= nxt inside {ST_CKE_HIGH, ST_DONE};
      cmdNop    <= (nxt != ST_DONE);
      initDone  <= (nxt == ST_DONE);
    end
  end

  // R1
  a_r1_quiet_unpowered: assert property (@(posedge clk) disable iff (!rstN)
    !pwrStable |=> (!memResetN && !memCke && cmdNop && !initDone));
  // R3
  a_r3_cke_low_at_release: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memResetN) |-> !memCke);
  // R5
  a_r5_nop_while_cke_rises: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memCke) |-> (cmdNop && !initDone));
  a_r5_done_needs_cke: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> (memCke && memResetN));
  // R6
  a_r6_cke_held: assert property (@(posedge clk) disable iff (!rstN)
    (memCke && pwrStable) |=> memCke);
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (initDone && pwrStable) |=> initDone);

endmodule

// File: rtl/ddr_pwrup_seq.sv
`timescale 1ns / 1ps
module ddr_pwrup_seq
  import ddr_pwrup_pkg::*;
#(
  parameter longint CLK_PERIOD_PS = 10000,
  parameter longint RST_HOLD_PS   = 200_000_000,
  parameter longint CKE_SETUP_PS  = 10_000,
  parameter longint CKE_LOW_PS    = 500_000_000,
  parameter longint CLK_RUN_PS    = 10_000,
  parameter int     MIN_RUN_CYC   = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwrStable,
  output logic memResetN,
  output logic memCke,
  output logic cmdNop,
  output logic initDone
);

  localparam int RST_CYC   = cycles_for(RST_HOLD_PS, CLK_PERIOD_PS, 1);
  localparam int SETUP_CYC = cycles_for(CKE_SETUP_PS, CLK_PERIOD_PS, 1);
  localparam int LOW_CYC   = cycles_for(CKE_LOW_PS, CLK_PERIOD_PS, 1);
  localparam int RUN_CYC   = cycles_for(CLK_RUN_PS, CLK_PERIOD_PS,
                                        (MIN_RUN_CYC < 1) ? 1 : MIN_RUN_CYC);

  tmr_strobe_t strobe;
  logic        tDone;

  ddr_pwrup_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .pwrStable (pwrStable),
    .tDone     (tDone),
    .strobe    (strobe),
    .memResetN (memResetN),
    .memCke    (memCke),
    .cmdNop    (cmdNop),
    .initDone  (initDone)
  );

  ddr_pwrup_timer #(
    .RST_CYC   (RST_CYC),
    .SETUP_CYC (SETUP_CYC),
    .LOW_CYC   (LOW_CYC),
    .RUN_CYC   (RUN_CYC)
  ) timer_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .tDone  (tDone)
  );

endmodule

// File: tb/ddr_pwrup_seq_tb.sv
`timescale 1ns / 1ps
module ddr_pwrup_seq_tb_top;

  // R8: 35ns/10ns -> 4, 5ns/10ns -> 1, 61ns/10ns -> 7, 10ns/10ns -> 1, raised to 5
  localparam int N_RST   = 4;
  localparam int N_SETUP = 1;
  localparam int N_LOW   = 7;
  localparam int N_RUN   = 5;
  localparam int T_REL   = N_RST + N_SETUP;
  localparam int T_CKE   = T_REL + N_LOW + N_RUN;
  localparam int T_DONE  = T_CKE + 1;
  localparam int SWEEP   = T_DONE + 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwrStable = 1'b0;
  logic memResetN, memCke, cmdNop, initDone;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ddr_pwrup_seq #(
    .CLK_PERIOD_PS (10000),
    .RST_HOLD_PS   (35000),
    .CKE_SETUP_PS  (5000),
    .CKE_LOW_PS    (61000),
    .CLK_RUN_PS    (10000),
    .MIN_RUN_CYC   (5)
  ) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .pwrStable (pwrStable),
    .memResetN (memResetN),
    .memCke    (memCke),
    .cmdNop    (cmdNop),
    .initDone  (initDone)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
    end
  endtask

  task automatic chkQuiet(string req);
    chk(req, "memResetN", memResetN, 1'b0);
    chk(req, "memCke", memCke, 1'b0);
    chk(req, "cmdNop", cmdNop, 1'b1);
    chk(req, "initDone", initDone, 1'b0);
  endtask

  // Edge index i counts from E0 = first posedge that samples pwrStable high
  task automatic sweep(int nEdges);
    for (int i = 0; i < nEdges; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk((i >= T_REL) ? "R2" : "R3", "memResetN", memResetN, (i >= T_REL));
      chk((i >= T_CKE) ? "R6" : "R4", "memCke", memCke, (i >= T_CKE));
      chk("R5", "cmdNop", cmdNop, !(i >= T_DONE));
      chk("R5", "initDone", initDone, (i >= T_DONE));
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #12;
    chkQuiet("R1");
    @(negedge clk);
    rstN = 1'b1;
    // R1: unpowered for a long stretch
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      chkQuiet("R1");
    end
    // R2..R6, R8: full sweep
    pwrStable = 1'b1;
    sweep(SWEEP);
    // R7: drop after done
    pwrStable = 1'b0;
    @(negedge clk);
    chkQuiet("R7");
    pwrStable = 1'b1;
    sweep(SWEEP);
    // R7: drop during the post-reset low wait
    pwrStable = 1'b0;
    @(negedge clk);
    pwrStable = 1'b1;
    sweep(T_REL + 3);
    pwrStable = 1'b0;
    @(negedge clk);
    chkQuiet("R7");
    @(negedge clk);
    chkQuiet("R7");
    pwrStable = 1'b1;
    sweep(SWEEP);
    // R1: master reset in the middle of the sequence
    pwrStable = 1'b0;
    @(negedge clk);
    pwrStable = 1'b1;
    sweep(T_CKE - 2);
    rstN = 1'b0;
    #2;
    chkQuiet("R1");
    @(negedge clk);
    rstN = 1'b1;
    sweep(SWEEP);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule